// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Transmitter

This block turns a 10-bit parallel word (a data byte plus two control bits) into a 12-bit serial frame. Every frame opens with a high start bit and closes with a low stop bit. Whatever the payload, each frame therefore carries at least one level change, and the low-to-high step at each frame boundary acts as the clock edge that the receiver recovers. The whole block runs on one fast system clock. A bit-rate enable pulse marks each serial bit time. The parallel clock arrives as an ordinary input that is sampled in that domain. The word is captured on its rising or falling edge, as chosen by a select input.

To help a receiver acquire lock, a sync request replaces the payload with a training pattern: five ones followed by five zeros. The pattern keeps going for a programmable number of frames after the request is withdrawn. An output-enable input gates the tri-state enable of the serial pin. A powerdown input silences the output and clears the bit position, so that sending resumes with a fresh frame once powerdown is released.

Top module: `txf_serializer`

## Requirements
- R1: Each frame has 12 bit times, sent in this order: a start bit of 1, then payload bits 0 through 9 (least significant first), then a stop bit of 0.
- R2: Every frame holds a transition: the bit after a frame's first enabled cycle is 1 and the bit after its twelfth enabled cycle is 0.
- R3: With `edge_sel_i` = 0 the word is captured on a rising edge of `pclk_i`, and with `edge_sel_i` = 1 on a falling edge; an edge of the other polarity leaves the captured word unchanged.
- R4: The captured word is copied into the frame at the frame's first bit time, so a new capture made mid-frame shows up only in the next frame.
- R5: A frame that starts while `sync_req_i` is high carries payload 10'h01F, so the serial order is five 1s and then five 0s.
- R6: After `sync_req_i` falls, exactly SYNC_FRAMES more frames carry the sync payload, and later frames carry the captured word.
- R7: `ser_oe_o` follows `oe_i` in the same cycle while the block is out of reset and not powered down.
- R8: While `pwrdn_i` is high, `ser_oe_o` is 0, `ser_o` goes to 0 on the next clock, parallel-clock edges and sync requests have no effect, and the bit position returns to the frame start, so the first enabled bit after release is a start bit.
- R9: `ser_o` changes only on the clock after a cycle with `bit_en_i` high.
- R10: During reset and for two clocks after `rst_ni` rises, `ser_oe_o` is 0 and `ser_o` is 0; the captured word resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one bit time per enabled cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Parallel word clock, sampled by clk_i |
| edge_sel_i | input | 1 | Capture edge: 0 rising, 1 falling |
| word_i | input | 10 | Parallel word: data byte in bits 7:0, control bits in 9:8 |
| bit_en_i | input | 1 | Serial bit-rate enable |
| sync_req_i | input | 1 | Request for the training pattern |
| oe_i | input | 1 | Serial output enable |
| pwrdn_i | input | 1 | Powerdown |
| ser_o | output | 1 | Serial data bit |
| ser_oe_o | output | 1 | Tri-state enable for the serial bit |

## Verification
A serial bit is due one clock after the enabled cycle that produces it, so the bench raises `bit_en_i` at a falling edge and reads each bit at the next falling edge. A word capture takes effect at the clock edge that follows the `pclk_i` change, and it shows up in the next frame at the earliest. `ser_oe_o` is combinational, so it is checked one time step after its inputs are driven. The effect of powerdown on `ser_o` is checked one clock later. Sync frames are counted frame by frame against SYNC_FRAMES, and a mid-frame pause in `bit_en_i` confirms that the output holds its value while no enable arrives.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // Role of the current bit time inside a frame.
  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_STOP  = 2'd2
  } slot_e;
endpackage

// File: rtl/txf_edge_capture.sv
module txf_edge_capture #(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic              fall_sel_i,
  input  logic              halt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_o
);
  logic              pclk_q;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              rise, fall, take;

  always_comb begin
    rise   = pclk_i & ~pclk_q;
    fall   = ~pclk_i & pclk_q;
    take   = (fall_sel_i ? fall : rise) & ~halt_i;
    hold_d = take ? word_i : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      hold_q <= '0;
    end else begin
      pclk_q <= pclk_i;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/txf_frame_ctrl.sv
module txf_frame_ctrl #(
  parameter int FRAME_LEN   = 12,
  parameter int SYNC_FRAMES = 1024,
  parameter int CNT_W       = 4,
  parameter int SC_W        = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             sync_req_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_start_o,
  output logic             use_sync_o,
  output logic [SC_W-1:0]  sync_left_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_LEN - 1);
  localparam logic [SC_W-1:0]  RELOAD = SC_W'(SYNC_FRAMES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SC_W-1:0]  sync_q, sync_d;
  logic             frame_start;

  always_comb begin
    frame_start = bit_en_i & ~halt_i & (cnt_q == '0);
    cnt_d       = cnt_q;
    sync_d      = sync_q;
    if (halt_i) begin
      cnt_d  = '0;
      sync_d = '0;
    end else begin
      if (bit_en_i) begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (sync_req_i) begin
        sync_d = RELOAD;
      end else if (frame_start && (sync_q != '0)) begin
        sync_d = sync_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign cnt_o         = cnt_q;
  assign frame_start_o = frame_start;
  assign use_sync_o    = sync_req_i | (sync_q != '0);
  assign sync_left_o   = sync_q;
endmodule

// File: rtl/txf_shifter.sv
module txf_shifter
  import txf_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              bit_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              frame_start_i,
  input  logic              use_sync_i,
  input  logic [WORD_W-1:0] hold_i,
  output logic              ser_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] STOP_POS = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sync_pat;
  logic [WORD_W-1:0] frame_q, frame_d;
  logic              ser_q, ser_d;
  logic [IDX_W-1:0]  idx;
  slot_e             slot;

  // Training payload: lower half ones, upper half zeros.
  for (genvar i = 0; i < WORD_W; i++) begin : g_pat
    assign sync_pat[i] = (i < WORD_W / 2);
  end

  always_comb begin
    idx = IDX_W'(cnt_i - 1'b1);
    if (cnt_i == '0)           slot = SLOT_START;
    else if (cnt_i == STOP_POS) slot = SLOT_STOP;
    else                        slot = SLOT_DATA;

    frame_d = frame_q;
    if (frame_start_i) begin
      frame_d = use_sync_i ? sync_pat : hold_i;
    end

    ser_d = ser_q;
    if (halt_i) begin
      ser_d = 1'b0;
    end else if (bit_en_i) begin
      case (slot)
        SLOT_START: ser_d = 1'b1;
        SLOT_STOP:  ser_d = 1'b0;
        default:    ser_d = frame_q[idx];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      ser_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      ser_q   <= ser_d;
    end
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/txf_serializer.sv
module txf_serializer #(
  parameter int WORD_W      = 10,
  parameter int SYNC_FRAMES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic              edge_sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              bit_en_i,
  input  logic              sync_req_i,
  input  logic              oe_i,
  input  logic              pwrdn_i,
  output logic              ser_o,
  output logic              ser_oe_o
);
  localparam int FRAME_LEN = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int SC_W      = $clog2(SYNC_FRAMES + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_q;
  logic [WORD_W-1:0] hold;
  logic [CNT_W-1:0]  cnt;
  logic              frame_start;
  logic              use_sync;
  logic [SC_W-1:0]   sync_left;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_q = rst_pipe_q[1];

  txf_edge_capture #(.WORD_W(WORD_W)) cap_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_q),
    .pclk_i     (pclk_i),
    .fall_sel_i (edge_sel_i),
    .halt_i     (pwrdn_i),
    .word_i     (word_i),
    .hold_o     (hold)
  );

  txf_frame_ctrl #(
    .FRAME_LEN   (FRAME_LEN),
    .SYNC_FRAMES (SYNC_FRAMES),
    .CNT_W       (CNT_W),
    .SC_W        (SC_W)
  ) ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_q),
    .bit_en_i      (bit_en_i),
    .sync_req_i    (sync_req_i),
    .halt_i        (pwrdn_i),
    .cnt_o         (cnt),
    .frame_start_o (frame_start),
    .use_sync_o    (use_sync),
    .sync_left_o   (sync_left)
  );

  txf_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shift_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_q),
    .halt_i        (pwrdn_i),
    .bit_en_i      (bit_en_i),
    .cnt_i         (cnt),
    .frame_start_i (frame_start),
    .use_sync_i    (use_sync),
    .hold_i        (hold),
    .ser_o         (ser_o)
  );

  assign ser_oe_o = oe_i & ~pwrdn_i & rst_n_q;
endmodule

// File: rtl/txf_serializer_chk.sv
module txf_serializer_chk #(
  parameter int FRAME_LEN = 12,
  parameter int CNT_W     = 4
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             bit_en_i,
  input logic             pwrdn_i,
  input logic [CNT_W-1:0] cnt,
  input logic             ser_o,
  input logic             ser_oe_o
);
  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt < CNT_W'(FRAME_LEN));

  assert_start_high_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bit_en_i && !pwrdn_i && cnt == '0) |=> ser_o);

  assert_stop_low_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bit_en_i && !pwrdn_i && cnt == CNT_W'(FRAME_LEN - 1)) |=> !ser_o);

  assert_pwrdn_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    pwrdn_i |=> (!ser_o && cnt == '0));

  assert_pwrdn_no_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    pwrdn_i |-> !ser_oe_o);

  assert_hold_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bit_en_i && !pwrdn_i) |=> $stable(ser_o));
endmodule

bind txf_serializer txf_serializer_chk #(
  .FRAME_LEN (FRAME_LEN),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_n    (rst_n_q),
  .bit_en_i (bit_en_i),
  .pwrdn_i  (pwrdn_i),
  .cnt      (cnt),
  .ser_o    (ser_o),
  .ser_oe_o (ser_oe_o)
);

// File: tb/txf_serializer_tb_top.sv
module txf_serializer_tb_top;
  localparam int NSYNC = 3;
  localparam logic [11:0] SYNC_FRAME = 12'h03F;

  logic       clk = 1'b0;
  logic       rst_ni, pclk_i, edge_sel_i, bit_en_i, sync_req_i, oe_i, pwrdn_i;
  logic [9:0] word_i;
  logic       ser_o, ser_oe_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  txf_serializer #(.WORD_W(10), .SYNC_FRAMES(NSYNC)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .pclk_i (pclk_i), .edge_sel_i (edge_sel_i),
    .word_i (word_i), .bit_en_i (bit_en_i), .sync_req_i (sync_req_i),
    .oe_i (oe_i), .pwrdn_i (pwrdn_i), .ser_o (ser_o), .ser_oe_o (ser_oe_o)
  );

  // {edge_sel, sync_req, word, expected frame in send order from bit 0}
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 1'b0, 10'h3A5, 12'h74B},
    {1'b1, 1'b0, 10'h000, 12'h001},
    {1'b0, 1'b0, 10'h3FF, 12'h7FF},
    {1'b1, 1'b0, 10'h155, 12'h2AB},
    {1'b0, 1'b0, 10'h2AA, 12'h555},
    {1'b0, 1'b1, 10'h123, 12'h03F}
  };

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send(input logic [11:0] exp, input string req);
    bit_en_i = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(req, {11'd0, ser_o}, {11'd0, exp[k]});
    end
    bit_en_i = 1'b0;
  endtask

  task automatic cap(input logic [9:0] w, input logic sel);
    edge_sel_i = sel;
    pclk_i = sel;
    @(negedge clk);
    word_i = w;
    pclk_i = ~sel;
    @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0; pclk_i = 1'b0; edge_sel_i = 1'b0; bit_en_i = 1'b0;
    sync_req_i = 1'b0; oe_i = 1'b1; pwrdn_i = 1'b0; word_i = '0;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", {11'd0, ser_oe_o}, 12'd0);
    chk("R10 ser in reset", {11'd0, ser_o}, 12'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 oe held", {11'd0, ser_oe_o}, 12'd0);
    repeat (2) @(negedge clk);
    chk("R7 oe after reset", {11'd0, ser_oe_o}, 12'd1);
    send(12'h001, "R10 zero word");

    // Vector table: R1 framing, R3 edge choice, R5 sync payload.
    for (int i = 0; i < 6; i++) begin
      cap(VEC[i][21:12], VEC[i][23]);
      sync_req_i = VEC[i][22];
      send(VEC[i][11:0], VEC[i][22] ? "R5" : (VEC[i][23] ? "R3 R1" : "R1"));
      sync_req_i = 1'b0;
    end

    // R6: NSYNC more pattern frames, then data.
    for (int f = 0; f < NSYNC; f++) send(SYNC_FRAME, "R6 tail");
    send(12'h247, "R6 back to data");

    // R4 / R9: pause mid-frame, capture a new word, output holds.
    bit_en_i = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R4 frame", {11'd0, ser_o}, {11'd0, 12'h247 >> k} & 12'd1);
      if (k == 4) begin
        logic held;
        held = ser_o;
        bit_en_i = 1'b0;
        cap(10'h0F0, 1'b0);
        chk("R9 held", {11'd0, ser_o}, {11'd0, held});
        bit_en_i = 1'b1;
      end
    end
    bit_en_i = 1'b0;
    send(12'h1E1, "R4 next frame");

    // R3: rising edge ignored in falling mode.
    edge_sel_i = 1'b1; pclk_i = 1'b0;
    @(negedge clk);
    word_i = 10'h0C3; pclk_i = 1'b1;
    @(negedge clk);
    send(12'h1E1, "R3 wrong edge");
    pclk_i = 1'b0;
    @(negedge clk);
    send(12'h187, "R3 falling edge");

    // R7: output enable follows oe_i.
    oe_i = 1'b0; #1;
    chk("R7 oe low", {11'd0, ser_oe_o}, 12'd0);
    oe_i = 1'b1; #1;
    chk("R7 oe high", {11'd0, ser_oe_o}, 12'd1);
    @(negedge clk);

    // R8: powerdown mid-frame.
    bit_en_i = 1'b1;
    repeat (5) @(negedge clk);
    bit_en_i = 1'b0; pwrdn_i = 1'b1; #1;
    chk("R8 oe off", {11'd0, ser_oe_o}, 12'd0);
    @(negedge clk);
    chk("R8 ser low", {11'd0, ser_o}, 12'd0);
    cap(10'h2F0, 1'b0);
    sync_req_i = 1'b1;
    @(negedge clk);
    sync_req_i = 1'b0;
    @(negedge clk);
    pwrdn_i = 1'b0;
    @(negedge clk);
    chk("R7 oe restored", {11'd0, ser_oe_o}, 12'd1);
    send(12'h187, "R8 restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule